// File: doc/BRIEF.md
# Quad Power-Rail Sequencer Controller

This block is a synchronous controller for bringing four downstream power converters up and down in a fixed order. It watches two supply-window flags: one says the supply is above its undervoltage threshold, the other says it is below its overvoltage threshold. It also watches a sequence request input. All three inputs are asynchronous and pass through two-flop synchronizers before the state machine sees them.

When the window is good and sequencing is requested, the controller waits a programmable start delay and then turns on rail A. Rails B, C and D follow in that order, each after its own programmable gap. Withdrawing the request turns the rails off in reverse order, D first, and each rail's gap is reused on the way down. Losing the supply window drops every rail in the same cycle. A fault flag mirrors the synchronized window state. A parameter selects whether the enables are active high or active low. For automatic start at power-up, the integrator ties the request input high.

All delays are cycle counts. The start delay and the three gaps are 16-bit values driven from registers outside the block.

Top module: `rail_sequencer`

## Requirements
- R1: While reset is asserted, every rail is inactive, the fault flag is asserted, and the active-low variant drives all enable pins high.
- R2: Start needs the window good (both window flags 1) and the request high, all synchronized. Rail A turns active on the (S+4)th rising edge after those port values settle, where S is `start_dly_i`. If the window is bad, no rail turns on.
- R3: Rails B, C and D turn on in that order. Each one turns on G+1 edges after the previous rail, where G is its gap. The gap before B is `gap_dly_i[15:0]`, before C is `gap_dly_i[31:16]`, and before D is `gap_dly_i[47:32]`. The active level never changes by more than one rail per cycle while the window is good.
- R4: A falling request seen with all rails on drops D on the 3rd edge after the port change. After a rail drops, the next lower rail drops that dropped rail's gap plus 1 edges later, down to A.
- R5: A bad window drops all active rails together on the 3rd rising edge after the port change.
- R6: The fault flag rises on the 2nd rising edge after the window goes bad, and falls on the 2nd edge after it returns good.
- R7: A request that rises again during turn-off is ignored until all rails are off. The controller then restarts through the full start delay.
- R8: After a window fault, rail A comes back only after the full start delay, at S+4 edges after the window returns.
- R9: With the polarity parameter set to active low, every enable pin is the complement of the active-high variant, and the fault flag is unchanged.
- R10: Enables are always a thermometer pattern: rail k is active only if every rail below it is active.
- R11: A falling request during the start wait or the ramp-up removes the highest active rail at once; a rail still waiting for its gap never turns on.
- R12: Delay values of zero advance one step per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uv_ok_i | input | 1 | Supply above undervoltage threshold (async) |
| ov_ok_i | input | 1 | Supply below overvoltage threshold (async) |
| seq_en_i | input | 1 | Sequencing request, high to run (async) |
| start_dly_i | input | 16 | Start delay in cycles |
| gap_dly_i | input | 48 | Gaps before B, C and D, 16 bits each |
| rail_en_o | output | 4 | Enables, bit 0 = A to bit 3 = D, polarity per parameter |
| fault_o | output | 1 | Supply outside window |

## Verification
The hardest case to reach is a request that rises again in the middle of a reverse turn-off. It must be withdrawn after the ramp has finished and restored within the few cycles while rails are still dropping. A directed case does exactly that. A second directed case withdraws the request on the very edge where rail B would have turned on. A seeded random phase with small delays then toggles the window and request flags often enough to hit turn-offs, faults and restarts in every state. A cycle-level reference model in the bench checks each of these.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_UP,
    ST_ON,
    ST_DOWN
  } seq_state_e;
endpackage

// File: rtl/rs_sync.sv
module rs_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[k] <= '0;
        else        chain[k] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[k] <= '0;
        else        chain[k] <= chain[k-1];
      end
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/rs_timer.sv
module rs_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load_i)     cnt <= val_i;
    else if (cnt != '0)  cnt <= cnt - W'(1);
  end

  assign done_o = (cnt == '0);
endmodule

// File: rtl/rs_fsm.sv
module rs_fsm
  import rs_pkg::*;
#(
  parameter int NUM_RAILS = 4,
  parameter int DLY_W     = 16,
  parameter int LVL_W     = 3,
  parameter int GAP_W     = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_ok_i,
  input  logic             seq_ok_i,
  input  logic             step_done_i,
  input  logic [DLY_W-1:0] start_dly_i,
  input  logic [GAP_W-1:0] gap_dly_i,
  output logic             load_o,
  output logic [DLY_W-1:0] load_val_o,
  output logic [LVL_W-1:0] lvl_o
);
  localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(NUM_RAILS);
  localparam logic [LVL_W-1:0] LVL_ONE = LVL_W'(1);

  // gap that precedes rail index 'rail' (rail 1 = B)
  function automatic logic [DLY_W-1:0] gap_pick(input logic [GAP_W-1:0] gaps,
                                                input logic [LVL_W-1:0] rail);
    int idx;
    idx = int'(rail) - 1;
    if (idx < 0) idx = 0;
    return gaps[idx*DLY_W +: DLY_W];
  endfunction

  seq_state_e       state_q, state_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;

  always_comb begin
    state_d    = state_q;
    lvl_d      = lvl_q;
    load_o     = 1'b0;
    load_val_o = '0;
    if (!win_ok_i) begin
      state_d = ST_IDLE;
      lvl_d   = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (seq_ok_i) begin
            state_d    = ST_START;
            load_o     = 1'b1;
            load_val_o = start_dly_i;
          end
        end
        ST_START: begin
          if (!seq_ok_i) begin
            state_d = ST_IDLE;
          end else if (step_done_i) begin
            lvl_d      = LVL_ONE;
            state_d    = (LVL_ONE == LVL_MAX) ? ST_ON : ST_UP;
            load_o     = 1'b1;
            load_val_o = gap_pick(gap_dly_i, LVL_ONE);
          end
        end
        ST_UP: begin
          if (!seq_ok_i) begin
            lvl_d = lvl_q - LVL_ONE;
            if (lvl_q == LVL_ONE) begin
              state_d = ST_IDLE;
            end else begin
              state_d    = ST_DOWN;
              load_o     = 1'b1;
              load_val_o = gap_pick(gap_dly_i, lvl_q - LVL_ONE);
            end
          end else if (step_done_i) begin
            lvl_d = lvl_q + LVL_ONE;
            if (lvl_q + LVL_ONE == LVL_MAX) begin
              state_d = ST_ON;
            end else begin
              load_o     = 1'b1;
              load_val_o = gap_pick(gap_dly_i, lvl_q + LVL_ONE);
            end
          end
        end
        ST_ON: begin
          if (!seq_ok_i) begin
            lvl_d = lvl_q - LVL_ONE;
            if (lvl_q == LVL_ONE) begin
              state_d = ST_IDLE;
            end else begin
              state_d    = ST_DOWN;
              load_o     = 1'b1;
              load_val_o = gap_pick(gap_dly_i, lvl_q - LVL_ONE);
            end
          end
        end
        ST_DOWN: begin
          if (step_done_i) begin
            lvl_d = lvl_q - LVL_ONE;
            if (lvl_q == LVL_ONE) begin
              state_d = ST_IDLE;
            end else begin
              load_o     = 1'b1;
              load_val_o = gap_pick(gap_dly_i, lvl_q - LVL_ONE);
            end
          end
        end
        default: begin
          state_d = ST_IDLE;
          lvl_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lvl_q   <= '0;
    end else begin
      state_q <= state_d;
      lvl_q   <= lvl_d;
    end
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer #(
  parameter int NUM_RAILS   = 4,
  parameter int DLY_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter bit ACTIVE_LOW  = 1'b0
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           uv_ok_i,
  input  logic                           ov_ok_i,
  input  logic                           seq_en_i,
  input  logic [DLY_W-1:0]               start_dly_i,
  input  logic [(NUM_RAILS-1)*DLY_W-1:0] gap_dly_i,
  output logic [NUM_RAILS-1:0]           rail_en_o,
  output logic                           fault_o
);
  localparam int LVL_W = $clog2(NUM_RAILS + 1);
  localparam int GAP_W = (NUM_RAILS - 1) * DLY_W;

  logic [2:0]           raw_in;
  logic [2:0]           sync_in;
  logic                 win_ok;
  logic                 seq_ok;
  logic                 step_done;
  logic                 tmr_load;
  logic [DLY_W-1:0]     tmr_val;
  logic [LVL_W-1:0]     rail_lvl;
  logic [NUM_RAILS-1:0] rail_act;

  assign raw_in = {seq_en_i, ov_ok_i, uv_ok_i};

  rs_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_in),
    .q_o   (sync_in)
  );

  assign win_ok = sync_in[0] & sync_in[1];
  assign seq_ok = sync_in[2];

  rs_timer #(.W(DLY_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .done_o (step_done)
  );

  rs_fsm #(
    .NUM_RAILS (NUM_RAILS),
    .DLY_W     (DLY_W),
    .LVL_W     (LVL_W),
    .GAP_W     (GAP_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .win_ok_i    (win_ok),
    .seq_ok_i    (seq_ok),
    .step_done_i (step_done),
    .start_dly_i (start_dly_i),
    .gap_dly_i   (gap_dly_i),
    .load_o      (tmr_load),
    .load_val_o  (tmr_val),
    .lvl_o       (rail_lvl)
  );

  for (genvar i = 0; i < NUM_RAILS; i++) begin : g_rail
    assign rail_act[i] = (rail_lvl > LVL_W'(i));
  end

  if (ACTIVE_LOW) begin : g_pol_low
    assign rail_en_o = ~rail_act;
  end else begin : g_pol_high
    assign rail_en_o = rail_act;
  end

  assign fault_o = ~win_ok;
endmodule

// File: rtl/rs_checker.sv
module rs_checker #(
  parameter int NUM_RAILS = 4,
  parameter int LVL_W     = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 win_ok,
  input logic                 seq_ok,
  input logic                 step_done,
  input logic                 fault_o,
  input logic [LVL_W-1:0]     rail_lvl,
  input logic [NUM_RAILS-1:0] rail_act
);
  // R10: enables form a thermometer pattern
  p_thermo_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((NUM_RAILS'(rail_act + NUM_RAILS'(1))) & rail_act) == '0);

  // R10: level never exceeds the rail count
  p_lvl_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rail_lvl) <= NUM_RAILS);

  // R3: one rail per cycle at most while window is good
  p_one_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    win_ok |=> ((int'(rail_lvl) <= int'($past(rail_lvl)) + 1) &&
                (int'($past(rail_lvl)) <= int'(rail_lvl) + 1)));

  // R2: a rail turns on only with window good and request high
  p_rise_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rail_lvl > $past(rail_lvl)) |-> $past(win_ok && seq_ok));

  // R12: a rail turns on only when the delay timer has expired
  p_rise_timer_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rail_lvl > $past(rail_lvl)) |-> $past(step_done));

  // R5: bad window empties all rails on the next edge
  p_fault_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !win_ok |=> (rail_lvl == '0));

  // R6: fault flag implies rails inactive one cycle later
  p_fault_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |=> (rail_act == '0));
endmodule

bind rail_sequencer rs_checker #(.NUM_RAILS(NUM_RAILS), .LVL_W(LVL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .win_ok    (win_ok),
  .seq_ok    (seq_ok),
  .step_done (step_done),
  .fault_o   (fault_o),
  .rail_lvl  (rail_lvl),
  .rail_act  (rail_act)
);

// File: tb/sim_rail_sequencer.sv
`timescale 1ns/1ps
module sim_rail_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        uv = 1'b0, ov = 1'b0, seq = 1'b0;
  logic [15:0] sdly = 16'd5;
  logic [15:0] gb = 16'd2, gc = 16'd0, gd = 16'd3;
  logic [3:0]  en_hi, en_lo;
  logic        flt_hi, flt_lo;
  int          checks = 0, errors = 0;
  bit          cmp_en = 1'b0, done = 1'b0;

  always #2.5 clk = ~clk;

  rail_sequencer #(.ACTIVE_LOW(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .uv_ok_i(uv), .ov_ok_i(ov), .seq_en_i(seq),
    .start_dly_i(sdly), .gap_dly_i({gd, gc, gb}), .rail_en_o(en_hi), .fault_o(flt_hi));

  rail_sequencer #(.ACTIVE_LOW(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .uv_ok_i(uv), .ov_ok_i(ov), .seq_en_i(seq),
    .start_dly_i(sdly), .gap_dly_i({gd, gc, gb}), .rail_en_o(en_lo), .fault_o(flt_lo));

  // ---------------- reference model ----------------
  logic [2:0] m_s1 = 3'b000, m_s2 = 3'b000;
  int m_mode = 0, m_on = 0, m_wait = 0;

  function automatic int gap_of(int k);
    case (k)
      1: return int'(gb);
      2: return int'(gc);
      default: return int'(gd);
    endcase
  endfunction

  function automatic logic [3:0] thermo(int n);
    return 4'((1 << n) - 1);
  endfunction

  function automatic string mode_tag(int md);
    case (md)
      2, 3: return "R3";
      4: return "R4";
      default: return "R2";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 3'b000; m_s2 = 3'b000; m_mode = 0; m_on = 0; m_wait = 0;
    end else begin
      if (!(m_s2[0] && m_s2[1])) begin
        m_mode = 0; m_on = 0;
      end else begin
        case (m_mode)
          0: if (m_s2[2]) begin m_mode = 1; m_wait = int'(sdly); end
          1: if (!m_s2[2]) m_mode = 0;
             else if (m_wait == 0) begin m_on = 1; m_mode = 2; m_wait = gap_of(1); end
             else m_wait--;
          2: if (!m_s2[2]) begin
               m_on--;
               if (m_on == 0) m_mode = 0; else begin m_mode = 4; m_wait = gap_of(m_on); end
             end else if (m_wait == 0) begin
               m_on++;
               if (m_on == 4) m_mode = 3; else m_wait = gap_of(m_on);
             end else m_wait--;
          3: if (!m_s2[2]) begin m_on = 3; m_mode = 4; m_wait = gap_of(3); end
          default: if (m_wait == 0) begin
               m_on--;
               if (m_on == 0) m_mode = 0; else m_wait = gap_of(m_on);
             end else m_wait--;
        endcase
      end
      m_s2 = m_s1;
      m_s1 = {seq, ov, uv};
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      checks++;
      if (en_hi !== thermo(m_on)) begin
        errors++;
        $display("FAIL %s model rails actual=%b expected=%b", mode_tag(m_mode), en_hi, thermo(m_on));
      end
      checks++;
      if (flt_hi !== !(m_s2[0] && m_s2[1])) begin
        errors++;
        $display("FAIL R6 model fault actual=%b expected=%b", flt_hi, !(m_s2[0] && m_s2[1]));
      end
      checks++;
      if (en_lo !== ~en_hi || flt_lo !== flt_hi) begin
        errors++;
        $display("FAIL R9 polarity actual=%b/%b expected=%b/%b", en_lo, flt_lo, ~en_hi, flt_hi);
      end
      checks++;
      if (((en_hi + 4'd1) & en_hi) != 4'd0) begin
        errors++;
        $display("FAIL R10 thermometer actual=%b expected=thermometer", en_hi);
      end
    end
  end

  // ---------------- directed helpers ----------------
  task automatic step_chk(int n, string tag, logic [3:0] exp);
    repeat (n) @(negedge clk);
    checks++;
    if (en_hi !== exp) begin
      errors++;
      $display("FAIL %s rails actual=%b expected=%b", tag, en_hi, exp);
    end
  endtask

  task automatic fchk(int n, string tag, logic exp);
    repeat (n) @(negedge clk);
    checks++;
    if (flt_hi !== exp) begin
      errors++;
      $display("FAIL %s fault actual=%b expected=%b", tag, flt_hi, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state
    repeat (3) @(negedge clk);
    step_chk(0, "R1", 4'b0000);
    fchk(0, "R1", 1'b1);
    checks++;
    if (en_lo !== 4'b1111) begin
      errors++;
      $display("FAIL R1 active-low reset actual=%b expected=1111", en_lo);
    end
    rst_n = 1'b1;
    cmp_en = 1'b1;

    // R2/R3/R6: start delay 5, gaps 2,0,3
    uv = 1; ov = 1; seq = 1;
    fchk(1, "R6", 1'b1);
    fchk(1, "R6", 1'b0);
    step_chk(6, "R2", 4'b0000);
    step_chk(1, "R2", 4'b0001);
    step_chk(2, "R3", 4'b0001);
    step_chk(1, "R3", 4'b0011);
    step_chk(1, "R3", 4'b0111);
    step_chk(3, "R3", 4'b0111);
    step_chk(1, "R3", 4'b1111);
    checks++;
    if (en_lo !== 4'b0000) begin
      errors++;
      $display("FAIL R9 active-low full on actual=%b expected=0000", en_lo);
    end

    // R4: reverse turn-off
    seq = 0;
    step_chk(2, "R4", 4'b1111);
    step_chk(1, "R4", 4'b0111);
    step_chk(3, "R4", 4'b0111);
    step_chk(1, "R4", 4'b0011);
    step_chk(1, "R4", 4'b0001);
    step_chk(2, "R4", 4'b0001);
    step_chk(1, "R4", 4'b0000);

    // R7: request returns during turn-off
    seq = 1;
    step_chk(20, "R3", 4'b1111);
    seq = 0;
    step_chk(3, "R7", 4'b0111);
    seq = 1;
    step_chk(4, "R7", 4'b0011);
    step_chk(1, "R7", 4'b0001);
    step_chk(2, "R7", 4'b0001);
    step_chk(1, "R7", 4'b0000);
    step_chk(6, "R7", 4'b0000);
    step_chk(1, "R7", 4'b0001);

    // R5/R6/R8: window fault and recovery
    step_chk(10, "R3", 4'b1111);
    uv = 0;
    fchk(1, "R6", 1'b0);
    fchk(1, "R6", 1'b1);
    step_chk(0, "R5", 4'b1111);
    step_chk(1, "R5", 4'b0000);
    uv = 1;
    fchk(1, "R6", 1'b1);
    fchk(1, "R6", 1'b0);
    step_chk(6, "R8", 4'b0000);
    step_chk(1, "R8", 4'b0001);

    // R11: withdrawal on the edge B would turn on
    seq = 0;
    step_chk(2, "R11", 4'b0001);
    step_chk(1, "R11", 4'b0000);
    step_chk(10, "R11", 4'b0000);

    // R2: overvoltage blocks start
    ov = 0; seq = 1;
    step_chk(30, "R2", 4'b0000);
    fchk(0, "R6", 1'b1);

    // R12: all delays zero
    sdly = 0; gb = 0; gc = 0; gd = 0;
    ov = 1;
    step_chk(3, "R12", 4'b0000);
    step_chk(1, "R12", 4'b0001);
    step_chk(1, "R12", 4'b0011);
    step_chk(1, "R12", 4'b0111);
    step_chk(1, "R12", 4'b1111);

    // random phase, compared against the model every cycle
    for (int c = 0; c < 6000; c++) begin
      @(negedge clk);
      if ($urandom % 60 == 0) uv = ($urandom % 6) != 0;
      if ($urandom % 60 == 0) ov = ($urandom % 6) != 0;
      if ($urandom % 25 == 0) seq = ~seq;
      if ($urandom % 80 == 0) begin
        sdly = 16'($urandom % 7);
        gb   = 16'($urandom % 5);
        gc   = 16'($urandom % 5);
        gd   = 16'($urandom % 5);
      end
    end
    repeat (5) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule